// File: doc/BRIEF.md
# Per-Warp Register Hazard Scoreboard

This block keeps one pending flag for every architectural register of every warp in a SIMT core. A flag is set when an instruction that writes that register is issued, and it is cleared when that instruction's result is written back. While a flag is set, any later instruction of the same warp that reads or writes the register must wait.

The instruction buffer presents one candidate instruction at a time on a combinational query port: a warp id, up to three source registers (each with its own valid bit) and an optional destination. The block returns a read-after-write flag, a write-after-write flag and a ready bit. The buffer stores the ready bit as a mask bit, so instructions with hazards are hidden from the warp scheduler. A writeback arriving in the same cycle as a query is bypassed, so a register being released is already seen as free.

Top module: `sb_scoreboard`

## Requirements
- R1: A synchronous active-low reset clears every pending flag, so any query made after reset reports ready with no hazard.
- R2: `q_raw` is 1 and `q_ready` is 0 when any source whose valid bit is set names a register pending in the queried warp.
- R3: `q_waw` is 1 and `q_ready` is 0 when `q_dst_vld` is 1 and `q_dst` is pending in the queried warp.
- R4: `q_ready` equals NOT(`q_raw` OR `q_waw`); a source or destination field whose valid bit is 0 has no effect on the result.
- R5: An issue with `iss_valid`=1 and `iss_has_dst`=1 makes `iss_dst` pending in warp `iss_warp` from the next clock edge on.
- R6: A writeback with `wb_valid`=1 clears the pending flag of `wb_reg` in warp `wb_warp` at the next clock edge.
- R7: A query in the same cycle as a writeback to the same warp and register treats that register as free (writeback bypass).
- R8: An issue with `iss_has_dst`=0 (for example a store) reserves no register.
- R9: Warps are independent: a register pending in one warp never causes a hazard for a query of another warp.
- R10: When an issue reserves and a writeback releases the same warp and register in the same cycle, the register is pending after the edge.
- R11: Reserving a register that is pending and not being released in the same cycle is illegal and is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_warp | input | WARP_W (3) | Warp of the issuing instruction |
| iss_has_dst | input | 1 | Issuing instruction writes a register |
| iss_dst | input | REG_W (6) | Destination register to reserve |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_warp | input | WARP_W (3) | Warp of the written-back result |
| wb_reg | input | REG_W (6) | Register to release |
| q_warp | input | WARP_W (3) | Warp of the queried instruction |
| q_src_vld | input | NUM_SRC (3) | Valid bit per source operand |
| q_src | input | NUM_SRC*REG_W (18) | Source registers, source k in bits [k*REG_W +: REG_W] |
| q_dst_vld | input | 1 | Queried instruction has a destination |
| q_dst | input | REG_W (6) | Destination register of the query |
| q_raw | output | 1 | Read-after-write hazard found |
| q_waw | output | 1 | Write-after-write hazard found |
| q_ready | output | 1 | Instruction may be offered to the scheduler |

## Verification
Directed cases separate the two hazard kinds: a reserved register probed once as a source and once as a destination must raise only the matching flag, while the same register probed with its valid bit cleared, or from another warp, must raise neither. Same-cycle cases pit a writeback against a query (bypass must free the register) and against a fresh reservation (the reservation must win). Random traffic then concentrates registers in a small range across all warps so pending flags collide often, and compares all three outputs each cycle against a bench-side table of pending flags, which exposes errors in indexing, in release and in the bypass path.

// File: rtl/sb_pkg.sv
// Shared parameters and index types of the hazard scoreboard.
// Assumes warp and register counts are powers of two so that
// {warp, reg} forms a dense flat index.
package sb_pkg;
    parameter int NUM_WARPS = 8;
    parameter int NUM_REGS  = 64;
    parameter int NUM_SRC   = 3;
    localparam int WARP_W = $clog2(NUM_WARPS);
    localparam int REG_W  = $clog2(NUM_REGS);
    localparam int IDX_W  = WARP_W + REG_W;
    localparam int NUM_BITS = NUM_WARPS * NUM_REGS;

    typedef logic [WARP_W-1:0] warp_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/sb_pending_table.sv
// Holds one pending flag per (warp, register). Issue sets a flag,
// writeback clears one; if both hit the same flag in one cycle the
// reservation wins. Assumes the issuer never reserves a flag that is
// still pending unless it is released in the same cycle.
module sb_pending_table
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  idx_t                set_idx,
    input  logic                clr_en,
    input  idx_t                clr_idx,
    output logic [NUM_BITS-1:0] pend
);
    // Update the flags: clear first, then set so a reservation wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            if (clr_en) pend[clr_idx] <= 1'b0;
            if (set_en) pend[set_idx] <= 1'b1;
        end
    end

    // R1: reset leaves the table empty.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pend == '0));

    // R5: a reservation is visible after the edge.
    a_r5_reserve_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend[$past(set_idx)]);

    // R6: a release without a competing reservation frees the flag.
    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend[$past(clr_idx)]);

    // R8: with no reservation and no release the table holds.
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(pend));

    // R11: never reserve a flag that is already pending and not released.
    a_r11_no_double_reserve: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && pend[set_idx] && !(clr_en && clr_idx == set_idx)));
endmodule

// File: rtl/sb_hazard_check.sv
// Combinational hazard evaluation for one candidate instruction.
// Looks up each valid source and the optional destination in the
// pending table of the queried warp, with same-cycle writeback bypass.
module sb_hazard_check
    import sb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_BITS-1:0]      pend,
    input  logic                     wb_valid,
    input  idx_t                     wb_idx,
    input  warp_t                    q_warp,
    input  logic [NUM_SRC-1:0]       q_src_vld,
    input  logic [NUM_SRC*REG_W-1:0] q_src,
    input  logic                     q_dst_vld,
    input  reg_t                     q_dst,
    output logic                     q_raw,
    output logic                     q_waw,
    output logic                     q_ready
);
    logic [NUM_SRC-1:0] src_hit;
    idx_t               dst_idx;
    logic               dst_busy;

    // One lookup per source operand.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        idx_t src_idx;
        logic src_busy;
        assign src_idx  = {q_warp, q_src[s*REG_W +: REG_W]};
        // Flag is busy unless released this very cycle.
        assign src_busy = pend[src_idx] && !(wb_valid && wb_idx == src_idx);
        assign src_hit[s] = q_src_vld[s] && src_busy;
    end

    assign dst_idx  = {q_warp, q_dst};
    // Destination lookup with the same bypass.
    assign dst_busy = pend[dst_idx] && !(wb_valid && wb_idx == dst_idx);

    // Combine hazards into the ready flag.
    always_comb begin
        q_raw   = |src_hit;
        q_waw   = q_dst_vld && dst_busy;
        q_ready = !(q_raw || q_waw);
    end

    // R7: a register released this cycle never raises a WAW.
    a_r7_bypass_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && q_dst_vld && wb_idx == dst_idx) |-> !q_waw);

    // R3: a destination with its valid bit low raises no WAW.
    a_r3_dst_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !q_dst_vld |-> !q_waw);

    // R4: with no valid operand the instruction is always ready.
    a_r4_no_operands_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (q_src_vld == '0 && !q_dst_vld) |-> q_ready);
endmodule

// File: rtl/sb_scoreboard.sv
// Top of the per-warp register hazard scoreboard. Reserves a
// destination at issue, releases it at writeback and answers a
// combinational RAW/WAW query for the instruction buffer.
// Assumes NUM_WARPS and NUM_REGS are powers of two.
module sb_scoreboard
    import sb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_valid,
    input  logic [WARP_W-1:0]        iss_warp,
    input  logic                     iss_has_dst,
    input  logic [REG_W-1:0]         iss_dst,
    input  logic                     wb_valid,
    input  logic [WARP_W-1:0]        wb_warp,
    input  logic [REG_W-1:0]         wb_reg,
    input  logic [WARP_W-1:0]        q_warp,
    input  logic [NUM_SRC-1:0]       q_src_vld,
    input  logic [NUM_SRC*REG_W-1:0] q_src,
    input  logic                     q_dst_vld,
    input  logic [REG_W-1:0]         q_dst,
    output logic                     q_raw,
    output logic                     q_waw,
    output logic                     q_ready
);
    logic [NUM_BITS-1:0] pend;
    logic                set_en;
    idx_t                set_idx;
    idx_t                wb_idx;

    // Only instructions that write a register reserve one.
    assign set_en  = iss_valid && iss_has_dst;
    assign set_idx = {iss_warp, iss_dst};
    assign wb_idx  = {wb_warp, wb_reg};

    sb_pending_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_idx (set_idx),
        .clr_en  (wb_valid),
        .clr_idx (wb_idx),
        .pend    (pend)
    );

    sb_hazard_check u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_idx),
        .q_warp    (q_warp),
        .q_src_vld (q_src_vld),
        .q_src     (q_src),
        .q_dst_vld (q_dst_vld),
        .q_dst     (q_dst),
        .q_raw     (q_raw),
        .q_waw     (q_waw),
        .q_ready   (q_ready)
    );
endmodule

// File: tb/sb_scoreboard_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a bench-side table of pending registers.
module sb_scoreboard_tb;
    localparam int NW = 8;
    localparam int NR = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 0, iss_has_dst = 0, wb_valid = 0, q_dst_vld = 0;
    logic [2:0] iss_warp = 0, wb_warp = 0, q_warp = 0;
    logic [5:0] iss_dst = 0, wb_reg = 0, q_dst = 0;
    logic [2:0] q_src_vld = 0;
    logic [17:0] q_src = 0;
    logic       q_raw, q_waw, q_ready;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  mdl [NW][NR];

    always #2 clk = ~clk;

    sb_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .q_warp(q_warp), .q_src_vld(q_src_vld), .q_src(q_src),
        .q_dst_vld(q_dst_vld), .q_dst(q_dst),
        .q_raw(q_raw), .q_waw(q_waw), .q_ready(q_ready)
    );

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Pending as seen by a query this cycle (writeback bypass).
    function automatic bit seen_busy(logic [2:0] w, logic [5:0] r);
        return mdl[w][r] && !(wb_valid && wb_warp == w && wb_reg == r);
    endfunction

    function automatic bit exp_raw();
        bit h = 0;
        for (int s = 0; s < 3; s++)
            if (q_src_vld[s] && seen_busy(q_warp, q_src[s*6 +: 6])) h = 1;
        return h;
    endfunction

    function automatic bit exp_waw();
        return q_dst_vld && seen_busy(q_warp, q_dst);
    endfunction

    task automatic check_model(string tag);
        bit r = exp_raw();
        bit w = exp_waw();
        check_bit({tag, " R2"}, "q_raw", q_raw, r);
        check_bit({tag, " R3"}, "q_waw", q_waw, w);
        check_bit({tag, " R4"}, "q_ready", q_ready, !(r || w));
    endtask

    // Model state after the coming edge; reservation wins (R10).
    task automatic commit();
        if (wb_valid) mdl[wb_warp][wb_reg] = 0;
        if (iss_valid && iss_has_dst) mdl[iss_warp][iss_dst] = 1;
    endtask

    task automatic idle_inputs();
        iss_valid = 0; iss_has_dst = 0; wb_valid = 0;
        q_src_vld = 0; q_dst_vld = 0;
    endtask

    task automatic query(logic [2:0] w, logic [2:0] sv, logic [5:0] s0,
                         logic [5:0] s1, logic [5:0] s2, logic dv, logic [5:0] d);
        q_warp = w; q_src_vld = sv; q_src = {s2, s1, s0}; q_dst_vld = dv; q_dst = d;
    endtask

    initial begin
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++) mdl[w][r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        for (int w = 0; w < NW; w++) begin
            @(negedge clk); idle_inputs();
            query(w[2:0], 3'b111, 6'd0, 6'd5, 6'd63, 1'b1, 6'd1);
            #1 check_bit("R1", "q_ready after reset", q_ready, 1'b1);
            commit();
        end

        // R5: reserve w2 r5.
        @(negedge clk); idle_inputs();
        iss_valid = 1; iss_warp = 3'd2; iss_has_dst = 1; iss_dst = 6'd5;
        #1 commit();
        @(negedge clk); idle_inputs();
        query(3'd2, 3'b010, 6'd0, 6'd5, 6'd0, 1'b0, 6'd0);
        #1 check_bit("R2", "q_raw src1 pending", q_raw, 1'b1);
        check_bit("R5", "q_ready after reserve", q_ready, 1'b0);
        check_bit("R3", "q_waw without dst", q_waw, 1'b0);
        query(3'd2, 3'b000, 6'd0, 6'd0, 6'd0, 1'b1, 6'd5);
        #1 check_bit("R3", "q_waw dst pending", q_waw, 1'b1);
        check_bit("R3", "q_raw dst only", q_raw, 1'b0);
        // R4: invalid fields ignored.
        query(3'd2, 3'b101, 6'd1, 6'd5, 6'd2, 1'b0, 6'd5);
        #1 check_bit("R4", "q_ready invalid fields", q_ready, 1'b1);
        // R9: other warp unaffected.
        query(3'd3, 3'b001, 6'd5, 6'd0, 6'd0, 1'b1, 6'd5);
        #1 check_bit("R9", "q_ready other warp", q_ready, 1'b1);
        commit();

        // R7: bypass release same cycle.
        @(negedge clk); idle_inputs();
        wb_valid = 1; wb_warp = 3'd2; wb_reg = 6'd5;
        query(3'd2, 3'b100, 6'd0, 6'd0, 6'd5, 1'b1, 6'd5);
        #1 check_bit("R7", "q_ready with bypass", q_ready, 1'b1);
        commit();
        // R6: released for good.
        @(negedge clk); idle_inputs();
        query(3'd2, 3'b001, 6'd5, 6'd0, 6'd0, 1'b1, 6'd5);
        #1 check_bit("R6", "q_ready after release", q_ready, 1'b1);
        commit();

        // R8: no destination reserves nothing.
        @(negedge clk); idle_inputs();
        iss_valid = 1; iss_warp = 3'd1; iss_has_dst = 0; iss_dst = 6'd9;
        #1 commit();
        @(negedge clk); idle_inputs();
        query(3'd1, 3'b001, 6'd9, 6'd0, 6'd0, 1'b1, 6'd9);
        #1 check_bit("R8", "q_ready after store issue", q_ready, 1'b1);
        commit();

        // R10: reserve and release of the same register in one cycle.
        @(negedge clk); idle_inputs();
        iss_valid = 1; iss_warp = 3'd4; iss_has_dst = 1; iss_dst = 6'd1;
        #1 commit();
        @(negedge clk); idle_inputs();
        iss_valid = 1; iss_warp = 3'd4; iss_has_dst = 1; iss_dst = 6'd1;
        wb_valid = 1; wb_warp = 3'd4; wb_reg = 6'd1;
        #1 commit();
        @(negedge clk); idle_inputs();
        query(3'd4, 3'b001, 6'd1, 6'd0, 6'd0, 1'b0, 6'd0);
        #1 check_bit("R10", "q_raw after collide", q_raw, 1'b1);
        commit();

        // Random traffic against the model.
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] msk;
            @(negedge clk);
            msk = ($urandom % 4 != 0) ? 6'd7 : 6'd63;
            wb_valid = ($urandom % 3 == 0);
            wb_warp = 3'($urandom); wb_reg = 6'($urandom) & msk;
            iss_valid = ($urandom % 2 == 0);
            iss_warp = 3'($urandom); iss_dst = 6'($urandom) & msk;
            iss_has_dst = ($urandom % 5 != 0);
            if (iss_has_dst && mdl[iss_warp][iss_dst] &&
                !(wb_valid && wb_warp == iss_warp && wb_reg == iss_dst))
                iss_valid = 0;
            query(3'($urandom), 3'($urandom), 6'($urandom) & msk, 6'($urandom) & msk,
                  6'($urandom) & msk, 1'($urandom), 6'($urandom) & msk);
            #1 check_model("random");
            commit();
        end

        @(negedge clk); idle_inputs();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule